// File: doc/BRIEF.md
# Vector Operand Register Remap and Predicate Lookup

This block sits in front of an issue stage. It holds two small tables of keyed entries. A key is a register-file select (integer or floating point) plus a 5-bit register number. The first table marks registers as vectors. Each of its entries gives a start register to use in place of the keyed one, and an element-width code. The second table links registers to predicate registers. Each of its entries gives the register that holds the predicate bits, an invert flag and a zeroing flag.

Software fills both tables through one synchronous write port. The destination, first source and second source of the current instruction are looked up in parallel, with no clock between operand and result. Each operand gets its remapped register, its element width and its predicate settings. A single flag reports that no operand is vectorised, so that the issue stage can skip the expansion path.

Top module: `vl_operand_map`

## Requirements
- R1: Each table has 8 entries. A write with `wr_en_i` high updates the entry `wr_idx_i` of the table chosen by `wr_tbl_i` (0 = register table, 1 = predicate table), storing the valid bit, the key and the data. The result is seen by lookups from the next rising clock edge on, and an idle clock changes nothing.
- R2: An operand matches a register-table entry when that entry is valid and both its file select and its register number equal the operand's. A matched operand reports vec = 1. Its output register is data[4:0] of the entry and its element width is data[7:5].
- R3: An operand with no register-table match reports vec = 0. Its register number passes through unchanged and its element-width code is 0 (default).
- R4: Element-width codes are returned exactly as stored: 0 default, 1 = 8, 2 = 16, 3 = 32, 4 = 64, and 5 to 7 reserved.
- R5: When several valid entries of one table match the same key, the entry with the lowest index supplies the result.
- R6: `all_scalar_o` is 1 exactly when none of the three operands has vec = 1.
- R7: An operand that matches a valid predicate-table entry reports pred_en = 1, with the predicate register taken from data[4:0], invert from data[5] and zeroing from data[6]. data[7] is ignored.
- R8: An operand with no predicate-table match reports pred_en = 0 (all elements active), with the predicate register, invert and zeroing all 0.
- R9: Writing an entry with its valid bit 0 removes it. Asserting `rst_ni` low clears every entry of both tables.
- R10: The three operands are looked up independently in the same cycle. Different entries may map onto the same or overlapping start registers.
- R11: The same register number in the other register file does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Table write strobe |
| wr_tbl_i | input | 1 | 0 = register table, 1 = predicate table |
| wr_idx_i | input | ENT_IDX_W | Entry index |
| wr_valid_i | input | 1 | Valid bit to store |
| wr_fp_i | input | 1 | Key file select (1 = floating point) |
| wr_key_i | input | 5 | Key register number |
| wr_data_i | input | 8 | Entry data (layout per R2 / R7) |
| op_fp_i | input | 3 | File select per operand; bit 0 rd, 1 rs1, 2 rs2 |
| op_reg_i | input | 15 | Register numbers; [4:0] rd, [9:5] rs1, [14:10] rs2 |
| op_vec_o | output | 3 | Operand is vectorised |
| op_reg_o | output | 15 | Remapped register numbers |
| op_ew_o | output | 9 | Element-width codes, 3 bits per operand |
| op_pred_en_o | output | 3 | Predication active per operand |
| op_pred_reg_o | output | 15 | Predicate register per operand |
| op_pred_inv_o | output | 3 | Invert predicate per operand |
| op_pred_zero_o | output | 3 | Zero masked-off elements per operand |
| all_scalar_o | output | 1 | No operand is vectorised |

## Verification
The assertions run on every cycle. They check the following:
- A write lands in the addressed entry, a write with the valid bit clear removes it, and an idle cycle leaves the tables alone.
- Every scalar operand passes through with the default width.
- Whenever the all-scalar flag is high, no register is renamed.
- An operand without a predicate match reports only zeros.

Some behaviour depends on the table contents, so only the bench's scenarios can show it. This covers lowest-index priority when entries share a key, and keeping the two register files apart for the same number. It also covers reserved width codes coming back unchanged, and a shadowed entry showing through once the entry above it is removed. The bench also checks that a mid-run reset clears both tables.

// File: rtl/vl_pkg.sv
`timescale 1ns/1ps
package vl_pkg;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned EW_W   = 3;
  localparam int unsigned N_OP   = 3;
  localparam int unsigned DATA_W = 8;

  localparam logic [EW_W-1:0] EW_DEFAULT = 3'd0;

  typedef struct packed {
    logic             fp;
    logic [REG_W-1:0] num;
  } reg_key_t;

  // register table payload: [7:5] width code, [4:0] start register
  typedef struct packed {
    logic [EW_W-1:0]  ew;
    logic [REG_W-1:0] start;
  } reg_val_t;

  // predicate table payload: [6] zero, [5] invert, [4:0] predicate register
  typedef struct packed {
    logic             zero;
    logic             inv;
    logic [REG_W-1:0] preg;
  } pred_val_t;

  localparam int unsigned REG_VAL_W  = $bits(reg_val_t);
  localparam int unsigned PRED_VAL_W = $bits(pred_val_t);
endpackage

// File: rtl/vl_kv_table.sv
`timescale 1ns/1ps
module vl_kv_table
  import vl_pkg::*;
#(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned VAL_W  = 8,
  parameter int unsigned N_PORT = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic                           wr_valid_i,
  input  reg_key_t                       wr_key_i,
  input  logic [VAL_W-1:0]               wr_val_i,
  input  reg_key_t [N_PORT-1:0]          lk_key_i,
  output logic [N_PORT-1:0]              lk_hit_o,
  output logic [N_PORT-1:0][VAL_W-1:0]   lk_val_o
);
  localparam int unsigned N_ENT = 2 ** IDX_W;

  logic     [N_ENT-1:0]            valid_q;
  reg_key_t [N_ENT-1:0]            key_q;
  logic     [N_ENT-1:0][VAL_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      key_q   <= '0;
      val_q   <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= wr_valid_i;
      key_q[wr_idx_i]   <= wr_key_i;
      val_q[wr_idx_i]   <= wr_val_i;
    end
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    logic [N_ENT-1:0] match;
    logic [VAL_W-1:0] sel_val;

    always_comb begin
      for (int e = 0; e < N_ENT; e++)
        match[e] = valid_q[e] && (key_q[e] == lk_key_i[p]);
    end

    // scan from the top so the lowest matching index is applied last
    always_comb begin
      sel_val = '0;
      for (int e = N_ENT - 1; e >= 0; e--)
        if (match[e]) sel_val = val_q[e];
    end

    assign lk_hit_o[p] = |match;
    assign lk_val_o[p] = sel_val;
  end

  AST_WR_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_valid_i |=> valid_q[$past(wr_idx_i)] &&
      key_q[$past(wr_idx_i)] == $past(wr_key_i) &&
      val_q[$past(wr_idx_i)] == $past(wr_val_i)); // R1

  AST_WR_REMOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_valid_i |=> !valid_q[$past(wr_idx_i)]); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(valid_q) && $stable(key_q) && $stable(val_q)); // R1
endmodule

// File: rtl/vl_operand_resolve.sv
`timescale 1ns/1ps
module vl_operand_resolve
  import vl_pkg::*;
(
  input  reg_key_t         key_i,
  input  logic             reg_hit_i,
  input  reg_val_t         reg_val_i,
  input  logic             pred_hit_i,
  input  pred_val_t        pred_val_i,
  output logic             vec_o,
  output logic [REG_W-1:0] num_o,
  output logic [EW_W-1:0]  ew_o,
  output logic             pred_en_o,
  output logic [REG_W-1:0] pred_reg_o,
  output logic             pred_inv_o,
  output logic             pred_zero_o
);
  always_comb begin
    vec_o = reg_hit_i;
    if (reg_hit_i) begin
      num_o = reg_val_i.start;
      ew_o  = reg_val_i.ew;
    end else begin
      num_o = key_i.num;
      ew_o  = EW_DEFAULT;
    end
  end

  always_comb begin
    pred_en_o   = pred_hit_i;
    pred_reg_o  = pred_hit_i ? pred_val_i.preg : '0;
    pred_inv_o  = pred_hit_i & pred_val_i.inv;
    pred_zero_o = pred_hit_i & pred_val_i.zero;
  end
endmodule

// File: rtl/vl_operand_map.sv
`timescale 1ns/1ps
module vl_operand_map
  import vl_pkg::*;
#(
  parameter int unsigned ENT_IDX_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   wr_tbl_i,
  input  logic [ENT_IDX_W-1:0]   wr_idx_i,
  input  logic                   wr_valid_i,
  input  logic                   wr_fp_i,
  input  logic [REG_W-1:0]       wr_key_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [N_OP-1:0]        op_fp_i,
  input  logic [N_OP*REG_W-1:0]  op_reg_i,
  output logic [N_OP-1:0]        op_vec_o,
  output logic [N_OP*REG_W-1:0]  op_reg_o,
  output logic [N_OP*EW_W-1:0]   op_ew_o,
  output logic [N_OP-1:0]        op_pred_en_o,
  output logic [N_OP*REG_W-1:0]  op_pred_reg_o,
  output logic [N_OP-1:0]        op_pred_inv_o,
  output logic [N_OP-1:0]        op_pred_zero_o,
  output logic                   all_scalar_o
);
  reg_key_t                         wr_key;
  reg_key_t [N_OP-1:0]              op_key;
  logic     [N_OP-1:0]              reg_hit, pred_hit;
  logic     [N_OP-1:0][REG_VAL_W-1:0]  reg_val;
  logic     [N_OP-1:0][PRED_VAL_W-1:0] pred_val;

  assign wr_key = '{fp: wr_fp_i, num: wr_key_i};

  for (genvar i = 0; i < N_OP; i++) begin : g_key
    assign op_key[i] = '{fp: op_fp_i[i], num: op_reg_i[i*REG_W +: REG_W]};
  end

  vl_kv_table #(.IDX_W(ENT_IDX_W), .VAL_W(REG_VAL_W), .N_PORT(N_OP)) u_reg_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i && !wr_tbl_i),
    .wr_idx_i   (wr_idx_i),
    .wr_valid_i (wr_valid_i),
    .wr_key_i   (wr_key),
    .wr_val_i   (wr_data_i[REG_VAL_W-1:0]),
    .lk_key_i   (op_key),
    .lk_hit_o   (reg_hit),
    .lk_val_o   (reg_val)
  );

  vl_kv_table #(.IDX_W(ENT_IDX_W), .VAL_W(PRED_VAL_W), .N_PORT(N_OP)) u_pred_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i && wr_tbl_i),
    .wr_idx_i   (wr_idx_i),
    .wr_valid_i (wr_valid_i),
    .wr_key_i   (wr_key),
    .wr_val_i   (wr_data_i[PRED_VAL_W-1:0]),
    .lk_key_i   (op_key),
    .lk_hit_o   (pred_hit),
    .lk_val_o   (pred_val)
  );

  for (genvar i = 0; i < N_OP; i++) begin : g_op
    vl_operand_resolve u_res (
      .key_i       (op_key[i]),
      .reg_hit_i   (reg_hit[i]),
      .reg_val_i   (reg_val_t'(reg_val[i])),
      .pred_hit_i  (pred_hit[i]),
      .pred_val_i  (pred_val_t'(pred_val[i])),
      .vec_o       (op_vec_o[i]),
      .num_o       (op_reg_o[i*REG_W +: REG_W]),
      .ew_o        (op_ew_o[i*EW_W +: EW_W]),
      .pred_en_o   (op_pred_en_o[i]),
      .pred_reg_o  (op_pred_reg_o[i*REG_W +: REG_W]),
      .pred_inv_o  (op_pred_inv_o[i]),
      .pred_zero_o (op_pred_zero_o[i])
    );

    AST_SCALAR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !op_vec_o[i] |-> op_reg_o[i*REG_W +: REG_W] == op_reg_i[i*REG_W +: REG_W] &&
        op_ew_o[i*EW_W +: EW_W] == EW_DEFAULT); // R3

    AST_NO_PRED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !op_pred_en_o[i] |-> op_pred_reg_o[i*REG_W +: REG_W] == '0 &&
        !op_pred_inv_o[i] && !op_pred_zero_o[i]); // R8
  end

  assign all_scalar_o = ~|reg_hit;

  AST_ALL_SCALAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_scalar_o |-> op_reg_o == op_reg_i && op_ew_o == '0); // R6
endmodule

// File: tb/vl_operand_map_test.sv
`timescale 1ns/1ps
module vl_operand_map_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_tbl_i = 1'b0, wr_valid_i = 1'b0, wr_fp_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [4:0]  wr_key_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [2:0]  op_fp_i = '0;
  logic [14:0] op_reg_i = '0;
  logic [2:0]  op_vec_o, op_pred_en_o, op_pred_inv_o, op_pred_zero_o;
  logic [14:0] op_reg_o, op_pred_reg_o;
  logic [8:0]  op_ew_o;
  logic        all_scalar_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  vl_operand_map uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic tbl, input logic [2:0] idx, input logic vld,
                    input logic fp, input logic [4:0] key, input logic [7:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_tbl_i = tbl; wr_idx_i = idx; wr_valid_i = vld;
    wr_fp_i = fp; wr_key_i = key; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic look(input logic [2:0] fp, input logic [4:0] rs2, input logic [4:0] rs1,
                      input logic [4:0] rd);
    @(negedge clk_i);
    op_fp_i = fp; op_reg_i = {rs2, rs1, rd};
    #1;
  endtask

  // table rows: rd in low bits; data {ew,start}
  localparam logic [2:0]  T_FP  [4] = '{3'b010, 3'b000, 3'b110, 3'b001};
  localparam logic [14:0] T_REG [4] = '{{5'd7, 5'd5, 5'd5}, {5'd3, 5'd2, 5'd1},
                                        {5'd9, 5'd7, 5'd9}, {5'd31, 5'd5, 5'd5}};
  localparam logic [2:0]  E_VEC [4] = '{3'b111, 3'b000, 3'b001, 3'b011};
  localparam logic [14:0] E_REG [4] = '{{5'd10, 5'd20, 5'd10}, {5'd3, 5'd2, 5'd1},
                                        {5'd9, 5'd7, 5'd3}, {5'd31, 5'd10, 5'd20}};
  localparam logic [8:0]  E_EW  [4] = '{{3'd1, 3'd4, 3'd3}, 9'd0,
                                        {3'd0, 3'd0, 3'd6}, {3'd0, 3'd3, 3'd4}};

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R9 reset state
    look(3'b000, 5'd7, 5'd5, 5'd5);
    chk("R9 reset vec", op_vec_o, 3'b000);
    chk("R9 reset all_scalar", all_scalar_o, 1'b1);
    chk("R9 reset pred", op_pred_en_o, 3'b000);

    // register table
    wr(1'b0, 3'd0, 1'b1, 1'b0, 5'd5, {3'd3, 5'd10});
    wr(1'b0, 3'd1, 1'b1, 1'b1, 5'd5, {3'd4, 5'd20});
    wr(1'b0, 3'd2, 1'b1, 1'b0, 5'd7, {3'd1, 5'd10});
    wr(1'b0, 3'd3, 1'b1, 1'b0, 5'd5, {3'd2, 5'd30});
    wr(1'b0, 3'd4, 1'b1, 1'b0, 5'd9, {3'd6, 5'd3});
    // predicate table: data {pad, zero, inv, preg}
    wr(1'b1, 3'd0, 1'b1, 1'b0, 5'd5, {1'b1, 1'b0, 1'b1, 5'd1});
    wr(1'b1, 3'd1, 1'b1, 1'b1, 5'd2, {1'b0, 1'b1, 1'b0, 5'd4});

    // R2 R3 R4 R5 R6 R10 R11: vector table walk
    for (int r = 0; r < 4; r++) begin
      look(T_FP[r], T_REG[r][14:10], T_REG[r][9:5], T_REG[r][4:0]);
      chk("R2 R10 vec", op_vec_o, E_VEC[r]);
      chk("R2 R3 R5 reg", op_reg_o, E_REG[r]);
      chk("R4 ew", op_ew_o, E_EW[r]);
      chk("R6 all_scalar", all_scalar_o, (E_VEC[r] == 3'b000));
    end

    // R7 R8 R11 predicate lookups
    look(3'b010, 5'd2, 5'd2, 5'd5);
    chk("R7 pred_en", op_pred_en_o, 3'b011);
    chk("R7 pred_reg", op_pred_reg_o, {5'd0, 5'd4, 5'd1});
    chk("R7 pred_inv", op_pred_inv_o, 3'b001);
    chk("R7 pred_zero", op_pred_zero_o, 3'b010);
    chk("R8 R11 unmatched pred", {op_pred_en_o[2], op_pred_reg_o[14:10]}, 6'd0);

    // R1 write not seen before edge, R9 removal exposes lower priority entry
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_tbl_i = 1'b0; wr_idx_i = 3'd0; wr_valid_i = 1'b0;
    wr_fp_i = 1'b0; wr_key_i = 5'd5; wr_data_i = '0;
    op_fp_i = 3'b000; op_reg_i = {5'd0, 5'd0, 5'd5};
    #1;
    chk("R1 before edge", op_reg_o[4:0], 5'd10);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
    chk("R9 R5 removed entry", op_reg_o[4:0], 5'd30);
    chk("R9 R5 removed entry ew", op_ew_o[2:0], 3'd2);

    // R1 idle clocks hold contents
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 hold", op_reg_o[4:0], 5'd30);

    // R7 data bit 7 ignored: rewrite pred entry with bit7 set
    wr(1'b1, 3'd0, 1'b1, 1'b0, 5'd5, 8'b1100_0011);
    look(3'b000, 5'd0, 5'd0, 5'd5);
    chk("R7 pred rewrite", {op_pred_en_o[0], op_pred_zero_o[0], op_pred_inv_o[0],
                            op_pred_reg_o[4:0]}, {1'b1, 1'b1, 1'b0, 5'd3});

    // R9 mid-run reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    look(3'b010, 5'd7, 5'd5, 5'd5);
    chk("R9 reset clears reg", op_vec_o, 3'b000);
    chk("R9 reset clears pred", op_pred_en_o, 3'b000);
    chk("R9 reset passthrough", op_reg_o, {5'd7, 5'd5, 5'd5});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule